// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence Filter

This block watches a stream of 16-bit light readings and raises an interrupt when the readings stay outside a programmable window for long enough. Each time a new reading arrives with its valid strobe, the block compares it with an upper and a lower limit. It then counts how many readings in a row have landed on the same side of the window. When that run reaches the length chosen by a 2-bit persistence code, the block sets a sticky flag for that side and pulls an active-low, open-drain style interrupt output low.

The register interface around the block supplies the limits, the persistence code and an enable bit. It also supplies a one-cycle strobe when software reads the status word. That read clears both flags and releases the interrupt line. Clearing the enable bit resets the run counter and both flags. The status word places the two flags at fixed bit positions so that a register mux can return it unchanged.

Top module: `light_window_irq`

## Requirements
- R1: During and after reset, both flags are 0, `irqPinN` is 1 (released) and `statusWord` is 0.
- R2: A valid reading strictly greater than `upperLimit` is a high crossing. A valid reading strictly less than `lowerLimit` is a low crossing. A reading equal to either limit is inside the window. If a reading satisfies both crossing tests, it counts as a low crossing.
- R3: The persistence code selects the run length: code 0 means 1 reading, code 1 means 2, code 2 means 4 and code 3 means 8 consecutive crossings on the same side. The flag for that side is set on the clock edge that samples the reading which completes the run.
- R4: A valid reading inside the window sets the run count back to zero. Cycles in which `sampleValid` is 0 leave the run count unchanged.
- R5: A crossing on the side opposite to the current run starts a new run with a count of one.
- R6: Once set, a flag stays set until a status read or a disable. Later readings, whether inside the window or on the other side, do not clear it. The run count saturates at 8, and every further same-side crossing keeps the flag set.
- R7: A cycle with `statusRead` at 1 clears both flags at that clock edge. If a crossing sets a flag in the same cycle, that flag ends up set.
- R8: While `irqEnable` is 0, the run count and both flags are held at zero and readings have no effect. After the block is enabled again, a run starts from zero.
- R9: `statusWord` bit 15 is the low-side flag, bit 14 is the high-side flag, and bits 13 to 0 are 0.
- R10: `irqPinN` is 0 whenever either flag is set and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A new reading is present on `sampleData` this cycle |
| sampleData | input | 16 | Light reading |
| upperLimit | input | 16 | Upper window limit |
| lowerLimit | input | 16 | Lower window limit |
| persistCode | input | 2 | Run length code (1, 2, 4 or 8 readings) |
| irqEnable | input | 1 | Interrupt enable; 0 clears the run count and the flags |
| statusRead | input | 1 | One-cycle strobe when the status word is read; clears the flags |
| flagLow | output | 1 | Sticky low-side crossing flag |
| flagHigh | output | 1 | Sticky high-side crossing flag |
| statusWord | output | 16 | Status value for the register mux |
| irqPinN | output | 1 | Interrupt line; 0 means asserted, 1 means released |

## Verification
The flag-rise properties relate a flag edge to the reading, limits and enable sampled one cycle earlier. They therefore assume that all inputs are synchronous to `clk` and held stable across each sampling edge. The stimulus meets this by changing every input only on the falling edge. It changes the limits and the persistence code only between bursts, which keeps the cause of each flag edge unambiguous. Inverted limits (lower above upper) are permitted by the properties, and the stimulus applies them once to exercise the low-side priority.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

  // which side of the window the current run of crossings is on
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_LOW  = 2'd1,
    SIDE_HIGH = 2'd2
  } side_e;

  // strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic cntClear;    // run count to zero
    logic cntRestart;  // run count to one
    logic cntStep;     // run count plus one, saturating
    logic setLow;      // set the low-side flag
    logic setHigh;     // set the high-side flag
    logic readClear;   // status read: clear flags unless set this cycle
    logic flagsReset;  // disable: force both flags to zero
  } ctrl_strobes_t;

endpackage

// File: rtl/lwi_datapath.sv
module lwi_datapath
  import lwi_pkg::*;
#(
  parameter int DataWidth = 16,
  parameter int CodeWidth = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DataWidth-1:0] sampleData,
  input  logic [DataWidth-1:0] upperLimit,
  input  logic [DataWidth-1:0] lowerLimit,
  input  logic [CodeWidth-1:0] persistCode,
  input  ctrl_strobes_t        strobes,
  output logic                 isLow,
  output logic                 isHigh,
  output logic                 stepReach,
  output logic                 restartReach,
  output logic                 flagLow,
  output logic                 flagHigh
);

  // largest run length the code can ask for, and the counter that holds it
  localparam int MaxCount = 1 << ((1 << CodeWidth) - 1);
  localparam int CntWidth = $clog2(MaxCount + 1);

  logic [CntWidth-1:0] countQ;
  logic [CntWidth:0]   target;
  logic [CntWidth:0]   countPlus;
  logic                flagLowQ;
  logic                flagHighQ;

  // window comparison
  assign isLow  = sampleData < lowerLimit;
  assign isHigh = sampleData > upperLimit;

  // run length decode: 1 << code
  assign target       = (CntWidth + 1)'(1) << persistCode;
  assign countPlus    = {1'b0, countQ} + (CntWidth + 1)'(1);
  assign stepReach    = countPlus >= target;
  assign restartReach = target == (CntWidth + 1)'(1);

  // run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.cntClear) begin
      countQ <= '0;
    end else if (strobes.cntRestart) begin
      countQ <= CntWidth'(1);
    end else if (strobes.cntStep && (countQ != CntWidth'(MaxCount))) begin
      countQ <= countQ + CntWidth'(1);
    end
  end

  // sticky flags: a set in the same cycle as a read wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagLowQ  <= 1'b0;
      flagHighQ <= 1'b0;
    end else if (strobes.flagsReset) begin
      flagLowQ  <= 1'b0;
      flagHighQ <= 1'b0;
    end else begin
      flagLowQ  <= strobes.setLow  | (flagLowQ  & ~strobes.readClear);
      flagHighQ <= strobes.setHigh | (flagHighQ & ~strobes.readClear);
    end
  end

  assign flagLow  = flagLowQ;
  assign flagHigh = flagHighQ;

endmodule

// File: rtl/lwi_control.sv
module lwi_control
  import lwi_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          irqEnable,
  input  logic          sampleValid,
  input  logic          statusRead,
  input  logic          isLow,
  input  logic          isHigh,
  input  logic          stepReach,
  input  logic          restartReach,
  output ctrl_strobes_t strobes
);

  side_e sideQ;
  side_e sideNext;
  side_e crossSide;

  // low side takes priority when both tests pass (inverted window)
  always_comb begin
    if (isLow)       crossSide = SIDE_LOW;
    else if (isHigh) crossSide = SIDE_HIGH;
    else             crossSide = SIDE_NONE;
  end

  always_comb begin
    strobes  = '0;
    sideNext = sideQ;
    if (!irqEnable) begin
      strobes.cntClear   = 1'b1;
      strobes.flagsReset = 1'b1;
      sideNext           = SIDE_NONE;
    end else begin
      strobes.readClear = statusRead;
      if (sampleValid) begin
        if (crossSide == SIDE_NONE) begin
          strobes.cntClear = 1'b1;
          sideNext         = SIDE_NONE;
        end else if (crossSide == sideQ) begin
          strobes.cntStep = 1'b1;
          strobes.setLow  = stepReach && (crossSide == SIDE_LOW);
          strobes.setHigh = stepReach && (crossSide == SIDE_HIGH);
        end else begin
          strobes.cntRestart = 1'b1;
          sideNext           = crossSide;
          strobes.setLow     = restartReach && (crossSide == SIDE_LOW);
          strobes.setHigh    = restartReach && (crossSide == SIDE_HIGH);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sideQ <= SIDE_NONE;
    else       sideQ <= sideNext;
  end

endmodule

// File: rtl/light_window_irq.sv
module light_window_irq
  import lwi_pkg::*;
#(
  parameter int DataWidth   = 16,
  parameter int CodeWidth   = 2,
  parameter int StatusWidth = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic [DataWidth-1:0]   sampleData,
  input  logic [DataWidth-1:0]   upperLimit,
  input  logic [DataWidth-1:0]   lowerLimit,
  input  logic [CodeWidth-1:0]   persistCode,
  input  logic                   irqEnable,
  input  logic                   statusRead,
  output logic                   flagLow,
  output logic                   flagHigh,
  output logic [StatusWidth-1:0] statusWord,
  output logic                   irqPinN
);

  // fixed status positions: low flag on top bit, high flag just below
  localparam int LowBit  = StatusWidth - 1;
  localparam int HighBit = StatusWidth - 2;

  ctrl_strobes_t strobes;
  logic isLow;
  logic isHigh;
  logic stepReach;
  logic restartReach;

  lwi_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .irqEnable    (irqEnable),
    .sampleValid  (sampleValid),
    .statusRead   (statusRead),
    .isLow        (isLow),
    .isHigh       (isHigh),
    .stepReach    (stepReach),
    .restartReach (restartReach),
    .strobes      (strobes)
  );

  lwi_datapath #(
    .DataWidth (DataWidth),
    .CodeWidth (CodeWidth)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleData   (sampleData),
    .upperLimit   (upperLimit),
    .lowerLimit   (lowerLimit),
    .persistCode  (persistCode),
    .strobes      (strobes),
    .isLow        (isLow),
    .isHigh       (isHigh),
    .stepReach    (stepReach),
    .restartReach (restartReach),
    .flagLow      (flagLow),
    .flagHigh     (flagHigh)
  );

  always_comb begin
    statusWord          = '0;
    statusWord[LowBit]  = flagLow;
    statusWord[HighBit] = flagHigh;
  end

  // open-drain model: 0 pulls the line, 1 lets the pull-up win
  assign irqPinN = ~(flagLow | flagHigh);

endmodule

// File: rtl/lwi_checker.sv
module lwi_checker #(
  parameter int DataWidth = 16,
  parameter int CodeWidth = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleValid,
  input logic [DataWidth-1:0] sampleData,
  input logic [DataWidth-1:0] upperLimit,
  input logic [DataWidth-1:0] lowerLimit,
  input logic [CodeWidth-1:0] persistCode,
  input logic                 irqEnable,
  input logic                 statusRead,
  input logic                 flagLow,
  input logic                 flagHigh,
  input logic                 irqPinN
);

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |=> (!flagLow && !flagHigh));

  // R2
  low_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagLow) |-> $past(sampleValid && irqEnable && (sampleData < lowerLimit)));

  // R2
  high_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagHigh) |-> $past(sampleValid && irqEnable && (sampleData > upperLimit)
                              && !(sampleData < lowerLimit)));

  // R6
  low_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagLow && irqEnable && !statusRead) |=> flagLow);

  // R6
  high_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagHigh && irqEnable && !statusRead) |=> flagHigh);

  // R3
  single_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && sampleValid && (persistCode == '0) && (sampleData < lowerLimit)) |=> flagLow);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && statusRead && !sampleValid) |=> (!flagLow && !flagHigh && irqPinN));

endmodule

bind light_window_irq lwi_checker #(
  .DataWidth (DataWidth),
  .CodeWidth (CodeWidth)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .upperLimit  (upperLimit),
  .lowerLimit  (lowerLimit),
  .persistCode (persistCode),
  .irqEnable   (irqEnable),
  .statusRead  (statusRead),
  .flagLow     (flagLow),
  .flagHigh    (flagHigh),
  .irqPinN     (irqPinN)
);

// File: tb/light_window_irq_tb.sv
`timescale 1ns/1ps
module light_window_irq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = 16'd0;
  logic [15:0] upperLimit = 16'd1000;
  logic [15:0] lowerLimit = 16'd100;
  logic [1:0]  persistCode = 2'd0;
  logic        irqEnable = 1'b0;
  logic        statusRead = 1'b0;
  logic        flagLow;
  logic        flagHigh;
  logic [15:0] statusWord;
  logic        irqPinN;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curReq = "R1";

  // reference state
  int mCount = 0;
  int mSide = 0;   // 0 none, 1 low, 2 high
  bit mLow = 0;
  bit mHigh = 0;

  always #10 clk = ~clk;

  light_window_irq dut_i (
    .clk (clk), .rstN (rstN), .sampleValid (sampleValid), .sampleData (sampleData),
    .upperLimit (upperLimit), .lowerLimit (lowerLimit), .persistCode (persistCode),
    .irqEnable (irqEnable), .statusRead (statusRead), .flagLow (flagLow),
    .flagHigh (flagHigh), .statusWord (statusWord), .irqPinN (irqPinN)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = 0; mSide = 0; mLow = 0; mHigh = 0;
    end else if (!irqEnable) begin
      mCount = 0; mSide = 0; mLow = 0; mHigh = 0;
    end else begin
      int need;
      int kind;
      bit hit;
      bit sL;
      bit sH;
      need = 1 << persistCode;
      hit = 0; sL = 0; sH = 0;
      if (sampleValid) begin
        if (sampleData < lowerLimit)      kind = 1;
        else if (sampleData > upperLimit) kind = 2;
        else                              kind = 0;
        if (kind == 0) begin
          mCount = 0; mSide = 0;
        end else if (kind == mSide) begin
          hit = (mCount + 1) >= need;
          mCount = (mCount + 1 > 8) ? 8 : mCount + 1;
        end else begin
          mSide = kind; mCount = 1; hit = (need == 1);
        end
        sL = hit && (kind == 1);
        sH = hit && (kind == 2);
      end
      mLow  = sL | (mLow  & !statusRead);
      mHigh = sH | (mHigh & !statusRead);
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if ({flagLow, flagHigh} !== {mLow, mHigh}) begin
        errors++;
        $display("FAIL %s flags low/high actual %0d/%0d expected %0d/%0d",
                 curReq, flagLow, flagHigh, mLow, mHigh);
      end
      checks++;
      if (statusWord !== {mLow, mHigh, 14'd0}) begin
        errors++;
        $display("FAIL R9 statusWord actual %h expected %h", statusWord, {mLow, mHigh, 14'd0});
      end
      checks++;
      if (irqPinN !== !(mLow || mHigh)) begin
        errors++;
        $display("FAIL R10 irqPinN actual %0d expected %0d", irqPinN, !(mLow || mHigh));
      end
    end
  end

  task automatic cyc(input bit v, input logic [15:0] d, input bit rd);
    @(negedge clk);
    sampleValid = v;
    sampleData  = d;
    statusRead  = rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 16'd0, 0);
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(3);
    irqEnable = 1'b1;

    // R2: classification and limit equality
    curReq = "R2";
    cyc(1, 16'd1000, 0); cyc(1, 16'd100, 0); cyc(1, 16'd500, 0);
    cyc(1, 16'd1001, 0); idle(1);
    cyc(0, 16'd0, 1);
    cyc(1, 16'd99, 0); idle(1);
    cyc(0, 16'd0, 1);
    cyc(1, 16'h0000, 0); cyc(1, 16'hFFFF, 1); idle(1);
    cyc(0, 16'd0, 1);
    lowerLimit = 16'd2000; upperLimit = 16'd1000;   // inverted window
    cyc(1, 16'd1500, 0); idle(1);
    cyc(0, 16'd0, 1); idle(1);
    lowerLimit = 16'd100; upperLimit = 16'd1000;

    // R3: each persistence code
    curReq = "R3";
    for (int c = 1; c < 4; c++) begin
      cyc(1, 16'd500, 1);
      persistCode = 2'(c);
      for (int k = 0; k < (1 << c) - 1; k++) cyc(1, 16'd10, 0);
      idle(1);
      cyc(1, 16'd10, 0); idle(1);
      for (int k = 0; k < (1 << c); k++) cyc(1, 16'd3000, 0);
      idle(1);
    end
    cyc(1, 16'd500, 1);

    // R4: in-window breaks the run, idle cycles do not
    curReq = "R4";
    persistCode = 2'd2;
    cyc(1, 16'd5, 0); cyc(1, 16'd5, 0); cyc(1, 16'd5, 0);
    cyc(1, 16'd100, 0);
    cyc(1, 16'd5, 0); idle(2); cyc(1, 16'd5, 0); idle(3); cyc(1, 16'd5, 0);
    idle(1);
    cyc(1, 16'd5, 0); idle(1);
    cyc(1, 16'd500, 1);

    // R5: side change restarts at one
    curReq = "R5";
    persistCode = 2'd1;
    cyc(1, 16'd5, 0); cyc(1, 16'd5000, 0); cyc(1, 16'd5, 0); cyc(1, 16'd5000, 0);
    cyc(1, 16'd5000, 0); idle(1);

    // R6: sticky across other readings, saturated runs keep setting
    curReq = "R6";
    for (int k = 0; k < 6; k++) cyc(1, 16'd500, 0);
    cyc(1, 16'd5, 0); idle(2);
    cyc(0, 16'd0, 1);
    persistCode = 2'd3;
    for (int k = 0; k < 12; k++) cyc(1, 16'd5, 0);
    cyc(0, 16'd0, 1);
    cyc(1, 16'd5, 0); idle(1);

    // R7: read clears; a set in the same cycle wins
    curReq = "R7";
    cyc(0, 16'd0, 1);
    persistCode = 2'd0;
    cyc(1, 16'd5000, 0); idle(1);
    cyc(1, 16'd5, 1); idle(1);
    cyc(1, 16'd5, 1); cyc(0, 16'd0, 1); idle(1);

    // R8: disable clears and ignores readings
    curReq = "R8";
    cyc(1, 16'd5, 0); idle(1);
    @(negedge clk); irqEnable = 1'b0;
    persistCode = 2'd1;
    cyc(1, 16'd5, 0); cyc(1, 16'd5, 0); cyc(1, 16'd5, 0); idle(1);
    @(negedge clk); irqEnable = 1'b1;
    cyc(1, 16'd5, 0); idle(1);
    cyc(1, 16'd5, 0); idle(2);
    cyc(1, 16'd7, 0);
    @(negedge clk); irqEnable = 1'b0; sampleValid = 1'b0;
    idle(2);

    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL %s watchdog expired actual running expected done", curReq);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule